// File: doc/BRIEF.md
# Pin Event Detector with Grouped Interrupt Lines

This block watches a 54-pin input port and turns pin activity into latched events and interrupt requests. Each pin has four independent detect enables, for a rising edge, a falling edge, a high level and a low level, and any mix of them may be active at once. When an enabled condition occurs, the pin's status bit is set and stays set until software writes a 1 to it. The pin inputs are expected to be synchronized to the block clock already.

Status bits are ORed into three interrupt lines that each cover a fixed range of pins. Interrupt line 1 spans both 32-bit register words. Software configures the block through a simple 32-bit register bus with a write strobe, a byte address and combinational read data. Two further words per bank hold asynchronous edge enables. They are stored and read back only and have no effect on detection.

Top module: `evd_top`

## Requirements
- R1: After reset, every enable register, every status bit and all three interrupt lines are 0.
- R2: Register offsets are: status 0x40/0x44; rising-edge enables 0x4C/0x50; falling-edge enables 0x58/0x5C; high-level enables 0x64/0x68; low-level enables 0x70/0x74; async rising enables 0x7C/0x80; async falling enables 0x88/0x8C. The first word of each pair holds pins 0..31 at bit = pin, and the second word holds pins 32..53 at bit = pin-32. All enable words read back what was written. Bits 31..22 of every second word read 0.
- R3: With the rising enable set, a pin that was 0 at one clock edge and is 1 at the next sets its status bit at that next edge. A 1-to-0 transition does not set it.
- R4: With the falling enable set, a 1-to-0 transition sets the status bit at the edge where 0 is first sampled. A 0-to-1 transition does not set it.
- R5: With both edge enables set on one pin, each transition in either direction sets the status bit.
- R6: With the high-level enable set, the status bit is set on every edge where the pin is 1. A write-1 clear therefore leaves it set while the level persists, and the clear takes effect once the pin is 0.
- R7: With the low-level enable set, the status bit is set on every edge where the pin is 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and a bit changes only through a write-1 clear or a detection.
- R9: If a detection and a write-1 clear hit the same status bit at the same edge, the bit ends up set.
- R10: Clearing an enable does not clear a status bit that is already set.
- R11: Interrupt line 0 is the OR of status bits for pins 0..27, line 1 for pins 28..45 and line 2 for pins 46..53. Each line is registered and follows the status one clock later.
- R12: The async enable words have no influence on status bits or interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr_i | input | 8 | Byte address of the register word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pin_i | input | 54 | Synchronized pin levels |
| irq_o | output | 3 | Grouped interrupt lines, bit g is line g |

## Verification
A wrong previous-sample register would show up as a status bit set on the wrong transition direction. It would be visible on a status read one clock after the pin toggles. A status bit that dropped without a write-1, or that failed to set while its condition held, would reach the interrupt line one clock later. That makes group mismatches at pins 27/28 and 45/46 visible within two clocks of the stimulus. Enable storage faults show at once on read-back, including the unused upper bits of the second words.

// File: rtl/evd_pkg.sv
`timescale 1ns/1ps
package evd_pkg;
  localparam int unsigned AW     = 8;
  localparam int unsigned DW     = 32;
  localparam int unsigned NKIND  = 6;   // rise, fall, high, low, async rise, async fall
  localparam int unsigned STRIDE = 12;  // bytes between register kinds
  localparam logic [AW-1:0] STS_BASE = 8'h40;

  typedef enum int unsigned {
    K_RISE = 0, K_FALL = 1, K_HIGH = 2, K_LOW = 3, K_ARISE = 4, K_AFALL = 5
  } kind_e;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } bus_req_t;

  // byte address of enable kind k, bank b
  function automatic logic [AW-1:0] kind_addr(int unsigned k, int unsigned b);
    return AW'(int'(STS_BASE) + int'((k + 1) * STRIDE + b * 4));
  endfunction

  function automatic logic [AW-1:0] sts_addr(int unsigned b);
    return AW'(int'(STS_BASE) + int'(b * 4));
  endfunction
endpackage

// File: rtl/evd_cfg_regs.sv
`timescale 1ns/1ps
module evd_cfg_regs
  import evd_pkg::*;
#(
  parameter int unsigned NPINS = 54
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  bus_req_t                            req_i,
  output logic [NKIND-1:0][NPINS-1:0]         en_o
);
  localparam int unsigned HIW = NPINS - DW;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    logic [NPINS-1:0] en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q <= '0;
      end else if (req_i.we) begin
        if (req_i.addr == kind_addr(k, 0))
          en_q[DW-1:0] <= req_i.wdata;
        else if (req_i.addr == kind_addr(k, 1))
          en_q[NPINS-1:DW] <= req_i.wdata[HIW-1:0];
      end
    end
    assign en_o[k] = en_q;
  end
endmodule

// File: rtl/evd_detect.sv
`timescale 1ns/1ps
module evd_detect #(
  parameter int unsigned NPINS = 54
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] en_rise_i,
  input  logic [NPINS-1:0] en_fall_i,
  input  logic [NPINS-1:0] en_high_i,
  input  logic [NPINS-1:0] en_low_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] set_o,
  output logic [NPINS-1:0] sts_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic prev_q, sts_q, hit;
    always_comb begin
      hit = (en_rise_i[p] &  pin_i[p] & ~prev_q)
          | (en_fall_i[p] & ~pin_i[p] &  prev_q)
          | (en_high_i[p] &  pin_i[p])
          | (en_low_i[p]  & ~pin_i[p]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        sts_q  <= 1'b0;
      end else begin
        prev_q <= pin_i[p];
        sts_q  <= hit | (sts_q & ~clr_i[p]);  // detection beats clear
      end
    end
    assign set_o[p] = hit;
    assign sts_o[p] = sts_q;
  end
endmodule

// File: rtl/evd_irq_group.sv
`timescale 1ns/1ps
module evd_irq_group #(
  parameter int unsigned NPINS = 54,
  parameter int unsigned LO    = 0,
  parameter int unsigned HI    = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] sts_i,
  output logic             irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |sts_i[HI:LO];
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/evd_top.sv
`timescale 1ns/1ps
module evd_top
  import evd_pkg::*;
#(
  parameter int unsigned NPINS  = 54,
  parameter int unsigned G1_LO  = 28,
  parameter int unsigned G2_LO  = 46
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [2:0]       irq_o
);
  localparam int unsigned HIW  = NPINS - DW;
  localparam int unsigned NGRP = 3;
  localparam int unsigned GLO [NGRP] = '{0, G1_LO, G2_LO};
  localparam int unsigned GHI [NGRP] = '{G1_LO - 1, G2_LO - 1, NPINS - 1};

  bus_req_t                    req;
  logic [NKIND-1:0][NPINS-1:0] en_all;
  logic [NPINS-1:0]            clr_vec, set_vec, sts;

  assign req = '{we: bus_we_i, addr: bus_addr_i, wdata: bus_wdata_i};

  evd_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .en_o  (en_all)
  );

  always_comb begin
    clr_vec = '0;
    if (req.we && req.addr == sts_addr(0)) clr_vec[DW-1:0]    = req.wdata;
    if (req.we && req.addr == sts_addr(1)) clr_vec[NPINS-1:DW] = req.wdata[HIW-1:0];
  end

  evd_detect #(.NPINS(NPINS)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_i),
    .en_rise_i(en_all[K_RISE]),
    .en_fall_i(en_all[K_FALL]),
    .en_high_i(en_all[K_HIGH]),
    .en_low_i (en_all[K_LOW]),
    .clr_i    (clr_vec),
    .set_o    (set_vec),
    .sts_o    (sts)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    evd_irq_group #(.NPINS(NPINS), .LO(GLO[g]), .HI(GHI[g])) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sts_i (sts),
      .irq_o (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (req.addr == sts_addr(0)) bus_rdata_o = sts[DW-1:0];
    if (req.addr == sts_addr(1)) bus_rdata_o = DW'(sts[NPINS-1:DW]);
    for (int k = 0; k < NKIND; k++) begin
      if (req.addr == kind_addr(k, 0)) bus_rdata_o = en_all[k][DW-1:0];
      if (req.addr == kind_addr(k, 1)) bus_rdata_o = DW'(en_all[k][NPINS-1:DW]);
    end
  end
endmodule

// File: rtl/evd_chk.sv
`timescale 1ns/1ps
module evd_chk
  import evd_pkg::*;
#(
  parameter int unsigned NPINS = 54,
  parameter int unsigned G1_LO = 28,
  parameter int unsigned G2_LO = 46
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        bus_we_i,
  input logic [7:0]                  bus_addr_i,
  input logic [31:0]                 bus_wdata_i,
  input logic [31:0]                 bus_rdata_o,
  input logic [2:0]                  irq_o,
  input logic [NKIND-1:0][NPINS-1:0] en_i,
  input logic [NPINS-1:0]            set_i,
  input logic [NPINS-1:0]            sts_i
);
  localparam int unsigned HIW = NPINS - DW;

  logic [NPINS-1:0] clr_m, sync_en;
  logic             hi_word;

  always_comb begin
    clr_m = '0;
    if (bus_we_i && bus_addr_i == 8'h40) clr_m[31:0]       = bus_wdata_i;
    if (bus_we_i && bus_addr_i == 8'h44) clr_m[NPINS-1:32] = bus_wdata_i[HIW-1:0];
    sync_en = en_i[0] | en_i[1] | en_i[2] | en_i[3];
    hi_word = (bus_addr_i >= 8'h40) && (bus_addr_i <= 8'h8C)
           && (((bus_addr_i - 8'h40) % 8'd12) == 8'd4);
  end

  assert_hi_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_word |-> (bus_rdata_o[DW-1:HIW] == '0));

  assert_drop_needs_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sts_i) & ~sts_i & ~$past(clr_m)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(set_i) & ~sts_i) == '0));

  assert_async_no_effect_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sync_en) == '0) |-> ((sts_i & ~$past(sts_i)) == '0));

  assert_irq0_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] == $past(|sts_i[G1_LO-1:0]));

  assert_irq1_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[1] == $past(|sts_i[G2_LO-1:G1_LO]));

  assert_irq2_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[2] == $past(|sts_i[NPINS-1:G2_LO]));
endmodule

bind evd_top evd_chk #(.NPINS(NPINS), .G1_LO(G1_LO), .G2_LO(G2_LO)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .en_i       (en_all),
  .set_i      (set_vec),
  .sts_i      (sts)
);

// File: tb/sim_evd_top.sv
`timescale 1ns/1ps
module sim_evd_top;
  localparam logic [7:0] A_STS = 8'h40, A_RISE = 8'h4C, A_FALL = 8'h58,
                         A_HIGH = 8'h64, A_LOW = 8'h70, A_ARISE = 8'h7C, A_AFALL = 8'h88;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [53:0] pins = '0;
  logic [2:0]  irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  evd_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  function automatic logic [7:0] word_of(input logic [7:0] base, input int pin);
    return base + ((pin >= 32) ? 8'd4 : 8'd0);
  endfunction

  task automatic set_en(input logic [7:0] base, input int pin, input logic v);
    logic [31:0] d;
    rd(word_of(base, pin), d);
    d[pin % 32] = v;
    wr(word_of(base, pin), d);
  endtask

  task automatic sts_bit(input int pin, output logic b);
    logic [31:0] d;
    rd(word_of(A_STS, pin), d);
    b = d[pin % 32];
  endtask

  task automatic clr_pin(input int pin);
    wr(word_of(A_STS, pin), 32'h1 << (pin % 32));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 8'h40; a <= 8'h8C; a += 4) begin
      rd(8'(a), d);
      chk($sformatf("R1 reg %h after reset", a), d, 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(A_RISE + 8'd4, 32'hFFFF_FFFF);
    rd(A_RISE + 8'd4, d);
    chk("R2 rise hi word masks bits 31..22", d, 32'h003F_FFFF);
    for (int k = 0; k < 6; k++) begin
      wr(8'(A_RISE + 12 * k), 32'h5A00_0000 | 32'(k));
      wr(8'(A_RISE + 12 * k + 4), 32'hFFC0_0000 | 32'(k + 16));
    end
    for (int k = 0; k < 6; k++) begin
      rd(8'(A_RISE + 12 * k), d);
      chk($sformatf("R2 kind %0d lo readback", k), d, 32'h5A00_0000 | 32'(k));
      rd(8'(A_RISE + 12 * k + 4), d);
      chk($sformatf("R2 kind %0d hi readback", k), d, 32'(k + 16));
    end
    for (int k = 0; k < 6; k++) begin
      wr(8'(A_RISE + 12 * k), 32'h0);
      wr(8'(A_RISE + 12 * k + 4), 32'h0);
    end
    wr(A_STS, 32'hFFFF_FFFF);
    wr(A_STS + 8'd4, 32'hFFFF_FFFF);
    step(1);
    rd(A_STS, d);          chk("R2 status lo clean", d, 32'h0);
    rd(A_STS + 8'd4, d);   chk("R2 status hi clean", d, 32'h0);
  endtask

  task automatic t_rise;
    logic b;
    set_en(A_RISE, 3, 1'b1);
    pins[3] = 1'b1; step(1);
    sts_bit(3, b); chk("R3 rise sets pin 3", 32'(b), 32'h1);
    chk("R11 irq lags status by one clock", 32'(irq), 32'h0);
    step(1);
    chk("R11 irq0 from pin 3", 32'(irq), 32'h1);
    clr_pin(3);
    sts_bit(3, b); chk("R8 clear pin 3", 32'(b), 32'h0);
    step(1);
    chk("R11 irq0 drops after clear", 32'(irq), 32'h0);
    pins[3] = 1'b0; step(1);
    sts_bit(3, b); chk("R3 falling edge ignored", 32'(b), 32'h0);
    set_en(A_RISE, 3, 1'b0);
  endtask

  task automatic t_fall;
    logic b;
    set_en(A_FALL, 40, 1'b1);
    pins[40] = 1'b1; step(2);
    sts_bit(40, b); chk("R4 rising edge ignored", 32'(b), 32'h0);
    pins[40] = 1'b0; step(1);
    sts_bit(40, b); chk("R4 fall sets pin 40", 32'(b), 32'h1);
    step(1);
    chk("R11 irq1 from pin 40", 32'(irq), 32'h2);
    clr_pin(40);
    set_en(A_FALL, 40, 1'b0);
  endtask

  task automatic t_both;
    logic b;
    set_en(A_RISE, 50, 1'b1);
    set_en(A_FALL, 50, 1'b1);
    pins[50] = 1'b1; step(1);
    sts_bit(50, b); chk("R5 both: rise sets", 32'(b), 32'h1);
    clr_pin(50);
    sts_bit(50, b); chk("R5 both: no level set", 32'(b), 32'h0);
    pins[50] = 1'b0; step(1);
    sts_bit(50, b); chk("R5 both: fall sets", 32'(b), 32'h1);
    step(1);
    chk("R11 irq2 from pin 50", 32'(irq), 32'h4);
    clr_pin(50);
    set_en(A_RISE, 50, 1'b0);
    set_en(A_FALL, 50, 1'b0);
  endtask

  task automatic t_high;
    logic b;
    set_en(A_HIGH, 10, 1'b1);
    pins[10] = 1'b1; step(1);
    sts_bit(10, b); chk("R6 high level sets", 32'(b), 32'h1);
    clr_pin(10);
    sts_bit(10, b); chk("R6 level re-sets over clear", 32'(b), 32'h1);
    pins[10] = 1'b0;
    clr_pin(10);
    sts_bit(10, b); chk("R6 clear works once low", 32'(b), 32'h0);
    set_en(A_HIGH, 10, 1'b0);
  endtask

  task automatic t_low;
    logic b;
    set_en(A_LOW, 30, 1'b1);
    step(1);
    sts_bit(30, b); chk("R7 low level sets pin 30", 32'(b), 32'h1);
    step(1);
    chk("R11 pin 30 on irq1", 32'(irq), 32'h2);
    pins[30] = 1'b1;
    clr_pin(30);
    sts_bit(30, b); chk("R7 no set when high", 32'(b), 32'h0);
    set_en(A_LOW, 30, 1'b0);
    pins[30] = 1'b0; step(1);
    sts_bit(30, b); chk("R7 disabled low level ignored", 32'(b), 32'h0);
  endtask

  task automatic t_set_wins;
    logic b;
    set_en(A_RISE, 3, 1'b1);
    pins[3] = 1'b1; step(1);
    pins[3] = 1'b0; step(1);
    sts_bit(3, b); chk("R9 precondition set", 32'(b), 32'h1);
    pins[3] = 1'b1;
    clr_pin(3);
    sts_bit(3, b); chk("R9 set beats same-cycle clear", 32'(b), 32'h1);
    clr_pin(3);
    sts_bit(3, b); chk("R9 later clear works", 32'(b), 32'h0);
    pins[3] = 1'b0;
    set_en(A_RISE, 3, 1'b0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(A_RISE, 32'h3);
    pins[1:0] = 2'b11; step(1);
    pins[1:0] = 2'b00;
    wr(A_STS, 32'h0);
    rd(A_STS, d); chk("R8 write 0 keeps bits", d, 32'h3);
    wr(A_STS, 32'h2);
    rd(A_STS, d); chk("R8 write 1 clears only its bit", d, 32'h1);
    wr(A_STS, 32'h1);
    rd(A_STS, d); chk("R8 last bit cleared", d, 32'h0);
    wr(A_RISE, 32'h0);
  endtask

  task automatic t_en_clear;
    logic b;
    set_en(A_RISE, 5, 1'b1);
    pins[5] = 1'b1; step(1);
    set_en(A_RISE, 5, 1'b0);
    step(3);
    sts_bit(5, b); chk("R10 status kept after disable", 32'(b), 32'h1);
    clr_pin(5);
    pins[5] = 1'b0;
  endtask

  task automatic t_async;
    logic [31:0] d;
    wr(A_ARISE, 32'hFFFF_FFFF); wr(A_ARISE + 8'd4, 32'hFFFF_FFFF);
    wr(A_AFALL, 32'hFFFF_FFFF); wr(A_AFALL + 8'd4, 32'hFFFF_FFFF);
    pins = '1; step(2);
    pins = '0; step(2);
    rd(A_STS, d);        chk("R12 async enables inert lo", d, 32'h0);
    rd(A_STS + 8'd4, d); chk("R12 async enables inert hi", d, 32'h0);
    chk("R12 no irq", 32'(irq), 32'h0);
    wr(A_ARISE, 0); wr(A_ARISE + 8'd4, 0); wr(A_AFALL, 0); wr(A_AFALL + 8'd4, 0);
  endtask

  task automatic t_groups;
    int          bnd [4] = '{27, 28, 45, 46};
    logic [2:0]  grp [4] = '{3'b001, 3'b010, 3'b010, 3'b100};
    for (int i = 0; i < 4; i++) begin
      set_en(A_HIGH, bnd[i], 1'b1);
      pins[bnd[i]] = 1'b1; step(2);
      chk($sformatf("R11 pin %0d group", bnd[i]), 32'(irq), 32'(grp[i]));
      set_en(A_HIGH, bnd[i], 1'b0);
      pins[bnd[i]] = 1'b0;
      clr_pin(bnd[i]); step(1);
      chk($sformatf("R11 pin %0d irq released", bnd[i]), 32'(irq), 32'h0);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_regs;
    t_rise;
    t_fall;
    t_both;
    t_high;
    t_low;
    t_set_wins;
    t_w1c;
    t_en_clear;
    t_async;
    t_groups;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule